// File: doc/BRIEF.md
# Dual-Channel PWM Generator with Separate High and Low Lengths

This block produces two independent pulse-width-modulated outputs. Each waveform is described by two lengths rather than a period and a compare value: the number of prescaled ticks the output stays high, followed by the number it stays low. Both lengths sit in one 32-bit word per channel. A single shared control word carries, for both channels, the prescaler divide value, the choice of tick source, a clock enable and a run enable.

Four tick-enable inputs stand in for alternative clock sources. Each channel selects one of them, divides it by its prescaler, and advances its waveform position once per divided tick. Software programs the block through a small word-addressed register port with a combinational read path. A new pair of lengths written while a channel runs is held back until the current period ends, so no shortened or merged period can appear on the pin. Inverting a waveform is done by swapping the two lengths.

Top module: `dual_pwm_gen`

## Requirements
- R1: Word address 0 holds channel A's length word (byte offset 0x0), word 1 channel B's (0x4) and word 2 the shared control word (0x8); length words read back all 32 bits as written, and word 3 reads zero and ignores writes.
- R2: In a length word, bits 31:16 give the high length and bits 15:0 the low length, in prescaled ticks; each period starts with the high part, so the pin is high for high*(div+1) selected ticks and then low for low*(div+1) selected ticks.
- R3: The divide field is control bits 14:8 for channel A and 22:16 for channel B; the prescaler emits one advance per (field+1) selected ticks.
- R4: The source field is control bits 5:4 for A and 7:6 for B and picks tick input number field; while the picked input stays low the pin holds its level.
- R5: Clock enable is control bit 15 for A and 23 for B, run enable bit 0 for A and bit 1 for B; with either bit clear the pin is low from the clock edge that stores the control write onward, and on re-enabling the period restarts at the first high tick.
- R6: A high length of zero keeps the pin low throughout, a low length of zero keeps it high throughout, and both zero keeps it low.
- R7: A length word written while its channel runs takes effect only at the next period boundary.
- R8: The control word reads back as stored; its unused bits (all outside mask 0x00FFFFF3) read zero.
- R9: After reset all three registers read zero and both pins are low.
- R10: The two channels run independently with their own lengths, divide values and sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_src | input | 4 | Tick-enable inputs selectable as sources |
| pwm_out | output | 2 | PWM pins, bit 0 channel A, bit 1 channel B |

## Verification
The hardest situation to reach is a length write that lands in the middle of a running period, since it must stay invisible until that period ends. The stimulus waits for a rising edge on the pin, issues the write in the very next cycle, and then measures the rest of that high run, the following low run and the next full period against the old and new lengths. Random runs over lengths, divide values and sources with tick rates of one, one half and one quarter cover the prescaler arithmetic, and a source that never ticks shows the pin holding its level.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 7;
    localparam int SEL_W  = 2;
    localparam int NUM_CH = 2;
    localparam int NSRC   = 1 << SEL_W;

    localparam logic [ADDR_W-1:0] ADDR_LEN_A = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LEN_B = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd2;

    // field positions of channel ch in the shared control word
    function automatic int run_bit(int ch);
        return ch;
    endfunction
    function automatic int sel_lsb(int ch);
        return 4 + SEL_W * ch;
    endfunction
    function automatic int div_lsb(int ch);
        return 8 + 8 * ch;
    endfunction
    function automatic int ce_bit(int ch);
        return 15 + 8 * ch;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            m[run_bit(ch)] = 1'b1;
            m[ce_bit(ch)]  = 1'b1;
            for (int b = 0; b < SEL_W; b++) m[sel_lsb(ch) + b] = 1'b1;
            for (int b = 0; b < DIV_W; b++) m[div_lsb(ch) + b] = 1'b1;
        end
        return m;
    endfunction

    typedef struct packed {
        logic             run_en;
        logic             clk_en;
        logic [SEL_W-1:0] src_sel;
        logic [DIV_W-1:0] div;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_gen_regs.sv
module pwm_gen_regs
    import pwm_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] len_a,
    output logic [DATA_W-1:0] len_b,
    output logic [DATA_W-1:0] ctrl
);
    localparam logic [DATA_W-1:0] MASK = ctrl_mask();

    typedef struct packed {
        logic [DATA_W-1:0] len_a;
        logic [DATA_W-1:0] len_b;
        logic [DATA_W-1:0] ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_LEN_A: regs_d.len_a = bus_wdata;
                ADDR_LEN_B: regs_d.len_b = bus_wdata;
                ADDR_CTRL:  regs_d.ctrl  = bus_wdata & MASK;
                default:    regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_LEN_A: bus_rdata = regs_q.len_a;
            ADDR_LEN_B: bus_rdata = regs_q.len_b;
            ADDR_CTRL:  bus_rdata = regs_q.ctrl;
            default:    bus_rdata = '0;
        endcase
    end

    assign len_a = regs_q.len_a;
    assign len_b = regs_q.len_b;
    assign ctrl  = regs_q.ctrl;
endmodule

// File: rtl/pwm_gen_channel.sv
module pwm_gen_channel #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 7,
    parameter int SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en,
    input  logic                 clk_en,
    input  logic [SEL_W-1:0]     src_sel,
    input  logic [DIV_W-1:0]     div,
    input  logic [CNT_W-1:0]     hi_len,
    input  logic [CNT_W-1:0]     lo_len,
    input  logic [(1<<SEL_W)-1:0] tick_src,
    output logic                 pwm
);
    localparam int POS_W = CNT_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } st_t;

    st_t        st_d, st_q;
    logic       active;
    logic       adv;
    logic [POS_W-1:0] period;

    assign active = run_en & clk_en;
    assign period = POS_W'(st_q.hi) + POS_W'(st_q.lo);

    always_comb begin
        st_d = st_q;
        adv  = 1'b0;
        if (!active) begin
            // idle: clear counting state, keep the working lengths current
            st_d.pre = '0;
            st_d.pos = '0;
            st_d.hi  = hi_len;
            st_d.lo  = lo_len;
        end else begin
            if (tick_src[src_sel]) begin
                if (st_q.pre >= div) begin
                    st_d.pre = '0;
                    adv      = 1'b1;
                end else begin
                    st_d.pre = st_q.pre + DIV_W'(1);
                end
            end
            if (adv) begin
                if (st_q.pos + POS_W'(1) >= period) begin
                    // period boundary: restart and take the pending lengths
                    st_d.pos = '0;
                    st_d.hi  = hi_len;
                    st_d.lo  = lo_len;
                end else begin
                    st_d.pos = st_q.pos + POS_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm = active & (st_q.pos < POS_W'(st_q.hi));
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
    import pwm_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   tick_src,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [DATA_W-1:0] len_a_w, len_b_w, ctrl_w;
    logic [DATA_W-1:0] len_w [NUM_CH];

    pwm_gen_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .len_a    (len_a_w),
        .len_b    (len_b_w),
        .ctrl     (ctrl_w)
    );

    assign len_w[0] = len_a_w;
    assign len_w[1] = len_b_w;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int RB = run_bit(g);
        localparam int CB = ce_bit(g);
        localparam int SL = sel_lsb(g);
        localparam int DL = div_lsb(g);
        chan_cfg_t cfg;

        assign cfg.run_en  = ctrl_w[RB];
        assign cfg.clk_en  = ctrl_w[CB];
        assign cfg.src_sel = ctrl_w[SL +: SEL_W];
        assign cfg.div     = ctrl_w[DL +: DIV_W];

        pwm_gen_channel #(
            .CNT_W(CNT_W),
            .DIV_W(DIV_W),
            .SEL_W(SEL_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_en  (cfg.run_en),
            .clk_en  (cfg.clk_en),
            .src_sel (cfg.src_sel),
            .div     (cfg.div),
            .hi_len  (len_w[g][DATA_W-1 -: CNT_W]),
            .lo_len  (len_w[g][CNT_W-1:0]),
            .tick_src(tick_src),
            .pwm     (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_gen_checker.sv
module pwm_gen_checker
    import pwm_gen_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] ctrl,
    input logic [CNT_W-1:0]  hi_a,
    input logic [NSRC-1:0]   tick_src,
    input logic [NUM_CH-1:0] pwm_out
);
    localparam logic [DATA_W-1:0] MASK = ctrl_mask();

    logic act_a, act_b;
    assign act_a = ctrl[0] & ctrl[15];
    assign act_b = ctrl[1] & ctrl[23];

    // R5: a stopped channel drives its pin low
    a_r5_off_low_a: assert property (@(posedge clk) disable iff (!rst_n)
        !act_a |-> !pwm_out[0]);
    a_r5_off_low_b: assert property (@(posedge clk) disable iff (!rst_n)
        !act_b |-> !pwm_out[1]);

    // R5: re-enabling begins in the high part when the high length is nonzero
    a_r5_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a && !$past(act_a) && hi_a != '0) |-> pwm_out[0]);

    // R4: with no tick on any source the pin of a running channel holds
    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a && $past(act_a) && $past(tick_src) == '0) |-> $stable(pwm_out[0]));

    // R8: unused control bits stay zero, also on the read port
    a_r8_ctrl_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl & ~MASK) == '0);
    a_r8_read_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> ((bus_rdata & ~MASK) == '0));

    // R1: word 3 reads zero
    a_r1_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

bind dual_pwm_gen pwm_gen_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .ctrl     (ctrl_w),
    .hi_a     (len_a_w[31:16]),
    .tick_src (tick_src),
    .pwm_out  (pwm_out)
);

// File: tb/dual_pwm_gen_bench.sv
`timescale 1ns/1ps
module dual_pwm_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_src;
    logic [1:0]  pwm_out;
    logic [1:0]  tc = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // source 0 ticks every cycle, 1 every second, 2 never, 3 every fourth
    always @(negedge clk) tc <= tc + 2'd1;
    assign tick_src = {tc == 2'd0, 1'b0, tc[0], 1'b1};

    dual_pwm_gen u_dual_pwm_gen (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_src(tick_src), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] cw(int ch, bit run, bit ce, int sel, int dv);
        logic [31:0] w;
        w = '0;
        w[ch] = run;
        w[15 + 8*ch] = ce;
        w[4 + 2*ch +: 2] = sel[1:0];
        w[8 + 8*ch +: 7] = dv[6:0];
        return w;
    endfunction

    function automatic int src_factor(int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
    endfunction

    function automatic int exp_run(int len, int dv, int sel);
        return len * (dv + 1) * src_factor(sel);
    endfunction

    // full high run and following low run of one period, in cycles
    task automatic measure(input int ch, output int hi_n, output int lo_n);
        int g = 0;
        while (pwm_out[ch] !== 1'b0 && g < 4000) begin @(negedge clk); g++; end
        while (pwm_out[ch] !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
        hi_n = 0; lo_n = 0;
        while (pwm_out[ch] === 1'b1 && g < 4000) begin hi_n++; @(negedge clk); g++; end
        while (pwm_out[ch] === 1'b0 && g < 4000) begin lo_n++; @(negedge clk); g++; end
    endtask

    task automatic hold_level(input int ch, input logic lvl, input int n,
                              input string req, input string what);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch] !== lvl) bad++;
        end
        chk(bad == 0, req, what, bad, 0);
    endtask

    task automatic run_all();
        logic [31:0] d;
        int h, l, hr, hn, ln;

        // R9 reset state
        chk(pwm_out == 2'b00, "R9", "pins after reset", pwm_out, 0);
        for (int a = 0; a < 3; a++) begin
            rd(a[1:0], d);
            chk(d == 32'h0, "R9", "register after reset", d, 0);
        end

        // R1 map and readback, hole at word 3
        wr(2'd0, 32'h1234_5678);
        wr(2'd1, 32'h9abc_def0);
        wr(2'd3, 32'hffff_ffff);
        rd(2'd0, d); chk(d == 32'h1234_5678, "R1", "length A readback", d, 32'h1234_5678);
        rd(2'd1, d); chk(d == 32'h9abc_def0, "R1", "length B readback", d, 32'h9abc_def0);
        rd(2'd3, d); chk(d == 32'h0, "R1", "word 3 reads zero", d, 0);

        // R8 control readback with unused bits zero
        wr(2'd2, 32'hffff_ffff);
        rd(2'd2, d); chk(d == 32'h00ff_fff3, "R8", "control mask", d, 32'h00ff_fff3);
        wr(2'd2, 32'h0);

        // R2 R3 R4 random lengths, divide values and sources on both channels
        for (int it = 0; it < 12; it++) begin
            int ch = it % 2;
            int hv = $urandom_range(1, 12);
            int lv = $urandom_range(1, 12);
            int dv = $urandom_range(0, 3);
            int sx = $urandom_range(0, 2);
            int sl = (sx == 2) ? 3 : sx;
            wr(2'd2, 32'h0);
            wr(ch[1:0], {hv[15:0], lv[15:0]});
            wr(2'd2, cw(ch, 1, 1, sl, dv));
            measure(ch, h, l);
            chk(h == exp_run(hv, dv, sl), "R2", "high run (R3 R4 scaling)", h, exp_run(hv, dv, sl));
            chk(l == exp_run(lv, dv, sl), "R3", "low run", l, exp_run(lv, dv, sl));
        end

        // R10 both channels at once
        wr(2'd2, 32'h0);
        wr(2'd0, {16'd2, 16'd3});
        wr(2'd1, {16'd5, 16'd1});
        wr(2'd2, cw(0, 1, 1, 0, 0) | cw(1, 1, 1, 0, 1));
        measure(0, h, l);
        chk(h == 2 && l == 3, "R10", "channel A with B running", h * 100 + l, 203);
        measure(1, h, l);
        chk(h == 10 && l == 2, "R10", "channel B with A running", h * 100 + l, 1002);

        // R7 length write in mid period
        wr(2'd2, 32'h0);
        wr(2'd0, {16'd4, 16'd6});
        wr(2'd2, cw(0, 1, 1, 0, 0));
        while (pwm_out[0] !== 1'b0) @(negedge clk);
        while (pwm_out[0] !== 1'b1) @(negedge clk);
        bus_addr = 2'd0; bus_wdata = {16'd9, 16'd2}; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        hr = 0;
        while (pwm_out[0] === 1'b1 && hr < 100) begin hr++; @(negedge clk); end
        ln = 0;
        while (pwm_out[0] === 1'b0 && ln < 100) begin ln++; @(negedge clk); end
        hn = 0;
        while (pwm_out[0] === 1'b1 && hn < 100) begin hn++; @(negedge clk); end
        chk(hr + 1 == 4, "R7", "current high keeps old length", hr + 1, 4);
        chk(ln == 6, "R7", "current low keeps old length", ln, 6);
        chk(hn == 9, "R7", "next high uses new length", hn, 9);
        measure(0, h, l);
        chk(l == 2, "R7", "next low uses new length", l, 2);

        // R5 clock enable cleared, then restart at the first high tick
        wr(2'd2, cw(0, 1, 0, 0, 0));
        chk(pwm_out[0] == 1'b0, "R5", "pin low after clock enable cleared", pwm_out[0], 0);
        hold_level(0, 1'b0, 20, "R5", "stays low while stopped");
        wr(2'd2, cw(0, 1, 1, 0, 0));
        h = 0;
        while (pwm_out[0] === 1'b1 && h < 100) begin h++; @(negedge clk); end
        chk(h == 9, "R5", "restart gives a full high run", h, 9);
        wr(2'd2, cw(0, 0, 1, 0, 0));
        chk(pwm_out[0] == 1'b0, "R5", "pin low after run enable cleared", pwm_out[0], 0);

        // R4 a source that never ticks holds the level
        wr(2'd0, {16'd3, 16'd3});
        wr(2'd2, cw(0, 1, 1, 2, 0));
        chk(pwm_out[0] == 1'b1, "R4", "starts high", pwm_out[0], 1);
        hold_level(0, 1'b1, 100, "R4", "held with silent source");
        wr(2'd2, cw(0, 1, 1, 0, 0));
        measure(0, h, l);
        chk(h == 3 && l == 3, "R4", "runs after switching source", h * 100 + l, 303);

        // R6 zero lengths
        wr(2'd2, 32'h0);
        wr(2'd1, {16'd0, 16'd5});
        wr(2'd2, cw(1, 1, 1, 0, 0));
        hold_level(1, 1'b0, 100, "R6", "zero high length stays low");
        wr(2'd2, 32'h0);
        wr(2'd1, {16'd5, 16'd0});
        wr(2'd2, cw(1, 1, 1, 0, 0));
        hold_level(1, 1'b1, 100, "R6", "zero low length stays high");
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd2, cw(1, 1, 1, 0, 0));
        hold_level(1, 1'b0, 100, "R6", "both zero stays low");
        wr(2'd2, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                #(4 * 150000);
                checks++;
                errors++;
                $display("FAIL watchdog (all R): actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule